// File: doc/BRIEF.md
# PS/2 Host Receiver with Device Classification

This block is the receiving half of a host on a two-wire PS/2 link. The attached device drives a slow serial clock and a data line, both open-drain and pulled high. The block oversamples both lines with the system clock and filters out short glitches. It collects one 11-bit word across eleven falling edges of the device clock and checks the start, parity and stop bits. Each good byte goes out on a valid/ready stream. A malformed frame, a frame that stalls partway, or a byte that cannot be delivered gives a one-cycle error strobe instead.

Alongside the data path, a classifier watches every good byte, whether or not the consumer has taken it. When the device reports a passed self-test, the classifier starts deciding what is attached. A zero identity byte right after the self-test byte means a mouse. Any other byte, or silence until a timeout, means a keyboard. When host logic has sent an identity query, it pulses an input, and the classifier treats the next reply byte other than the acknowledge as the identity.

The host can inhibit the device by holding the clock line low. While the inhibit input is asserted, the receiver stops framing and discards any partial word without reporting an error.

Stream rules: `m_data` is meaningful only while `m_valid` is high. A byte stays presented, unchanged, until the cycle in which `m_ready` is high. There is one holding slot. A frame that completes while the slot is full and not being emptied in that same cycle is dropped, and the drop is reported on `err_pulse`. If the slot is emptied in the completion cycle, the new byte replaces the old one with no error.

Top module: `ps2_host_rx`

## Requirements
- R1: A word is taken bit by bit at eleven filtered falling edges of the device clock, in this order: a start bit 0, eight data bits least significant first, a parity bit giving the nine data-plus-parity bits an odd count of ones, and a stop bit 1. A good word raises `m_valid` with its byte on `m_data`.
- R2: A word whose start bit is 1, whose stop bit is 0, or whose parity count is even produces exactly one `err_pulse` cycle and does not raise `m_valid`.
- R3: If, after the first falling edge of a word, no further falling edge arrives within `BIT_TO_CYC` cycles, the partial word is dropped and `err_pulse` fires once. The next word is then received correctly.
- R4: A low pulse on the clock or data line that is shorter than `FILT_LEN` system cycles is ignored. It starts no word and causes no error.
- R5: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value. A word completing in such a cycle is dropped and gives `err_pulse`. A word completing in a cycle where `m_ready` is high replaces the byte with no error.
- R6: `ps2_clk_oe` (1 = pull the clock line low) follows `inhibit_i` one cycle later. While `inhibit_i` is high, no byte and no error is produced, and a partial word is discarded silently.
- R7: After reset, `m_valid`, `err_pulse` and `ps2_clk_oe` are 0 and `dev_type` is 0 (unknown). `dev_type` stays unknown until the self-test byte has been classified.
- R8: `dev_type` encodes 0 = unknown, 1 = keyboard, 2 = mouse. The byte 0xAA sets it to unknown and starts a wait. If the next good byte is 0x00, `dev_type` becomes mouse.
- R9: After 0xAA, a next byte other than 0x00 sets keyboard. If no byte arrives within `ID_WAIT_CYC` cycles, keyboard is also set.
- R10: After a pulse on `id_query_i`, 0xFA bytes are skipped. The first other byte sets mouse if it is 0x00 and keyboard otherwise. Without a query, a 0x00 byte outside the self-test wait leaves `dev_type` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Sensed level of the device clock line |
| ps2_dat_i | input | 1 | Sensed level of the data line |
| inhibit_i | input | 1 | Hold the device clock low and suspend reception |
| id_query_i | input | 1 | One-cycle pulse: an identity query was sent to the device |
| ps2_clk_oe | output | 1 | Pull-down enable for the clock line (1 = drive low) |
| m_valid | output | 1 | Received byte available |
| m_ready | input | 1 | Consumer takes the byte this cycle |
| m_data | output | 8 | Received byte |
| err_pulse | output | 1 | One-cycle error strobe (bad frame, timeout or overflow) |
| dev_type | output | 2 | 0 unknown, 1 keyboard, 2 mouse |

## Verification
Two things can fall in the same cycle: a new word completing, and the consumer emptying the holding slot. That cycle decides between replacing the byte and dropping it. The bench raises `m_ready` for exactly one cycle, timed to the completion of a word, while an earlier byte is still pending. It then expects the new byte on `m_data` with no error strobe. A second case leaves `m_ready` low through a completion and expects the old byte to be kept along with one error strobe.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  typedef enum logic [1:0] {
    DEV_UNKNOWN  = 2'd0,
    DEV_KEYBOARD = 2'd1,
    DEV_MOUSE    = 2'd2
  } dev_kind_e;

  localparam int         FRAME_BITS  = 11;
  localparam logic [7:0] SELFTEST_OK = 8'hAA;
  localparam logic [7:0] MOUSE_ID    = 8'h00;
  localparam logic [7:0] CMD_ACK     = 8'hFA;

endpackage

// File: rtl/ps2_line_filter.sv
// Two-flop synchronizer followed by a stability filter: the output level
// changes only after the synchronized input has differed for STABLE_CYC cycles.
module ps2_line_filter #(
  parameter int STABLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      level_o <= 1'b1;
      run_q   <= '0;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      if (s2_q == level_o) begin
        run_q <= '0;
      end else if (run_q == CW'(STABLE_CYC - 1)) begin
        level_o <= s2_q;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2_frame_rx.sv
// Collects one word on the falling edges of the filtered device clock,
// validates it and watches for a stalled word.
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int BIT_TO_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_lvl,
  input  logic       dat_lvl,
  input  logic       hold_i,
  output logic       frm_ok,
  output logic       frm_err,
  output logic [7:0] frm_byte
);
  localparam int TW       = $clog2(BIT_TO_CYC + 1);
  localparam int LAST_BIT = FRAME_BITS - 1;

  logic                  clk_prev_q;
  logic                  busy_q;
  logic [3:0]            bit_q;
  logic [FRAME_BITS-2:0] sr_q;
  logic [TW-1:0]         idle_q;
  logic [FRAME_BITS-1:0] word_next;
  logic                  fall;
  logic                  word_good;

  assign fall      = clk_prev_q & ~clk_lvl;
  assign word_next = {dat_lvl, sr_q};
  assign word_good = ~word_next[0] & word_next[LAST_BIT] & (^word_next[LAST_BIT-1:1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b1;
      busy_q     <= 1'b0;
      bit_q      <= '0;
      sr_q       <= '0;
      idle_q     <= '0;
      frm_ok     <= 1'b0;
      frm_err    <= 1'b0;
      frm_byte   <= '0;
    end else begin
      frm_ok     <= 1'b0;
      frm_err    <= 1'b0;
      clk_prev_q <= clk_lvl;
      if (hold_i) begin
        busy_q <= 1'b0;
        bit_q  <= '0;
        idle_q <= '0;
      end else if (fall) begin
        sr_q   <= word_next[LAST_BIT:1];
        idle_q <= '0;
        if (bit_q == 4'(LAST_BIT)) begin
          busy_q <= 1'b0;
          bit_q  <= '0;
          if (word_good) begin
            frm_ok   <= 1'b1;
            frm_byte <= word_next[8:1];
          end else begin
            frm_err <= 1'b1;
          end
        end else begin
          busy_q <= 1'b1;
          bit_q  <= bit_q + 1'b1;
        end
      end else if (busy_q) begin
        if (idle_q == TW'(BIT_TO_CYC - 1)) begin
          busy_q  <= 1'b0;
          bit_q   <= '0;
          idle_q  <= '0;
          frm_err <= 1'b1;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_dev_classify.sv
// Decides what is attached from the byte stream: self-test byte, then the
// identity byte or a timeout; also an identity reply after a host query.
module ps2_dev_classify
  import ps2_rx_pkg::*;
#(
  parameter int ID_WAIT_CYC = 2000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_ok,
  input  logic [7:0] byte_val,
  input  logic       query_i,
  output dev_kind_e  dev_o
);
  localparam int TW = $clog2(ID_WAIT_CYC + 1);

  logic          wait_id_q;
  logic          armed_q;
  logic [TW-1:0] tmr_q;
  dev_kind_e     verdict;

  assign verdict = (byte_val == MOUSE_ID) ? DEV_MOUSE : DEV_KEYBOARD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_o     <= DEV_UNKNOWN;
      wait_id_q <= 1'b0;
      armed_q   <= 1'b0;
      tmr_q     <= '0;
    end else begin
      if (byte_ok && byte_val == SELFTEST_OK) begin
        dev_o     <= DEV_UNKNOWN;
        wait_id_q <= 1'b1;
        armed_q   <= 1'b0;
        tmr_q     <= '0;
      end else if (byte_ok && wait_id_q) begin
        wait_id_q <= 1'b0;
        dev_o     <= verdict;
      end else if (byte_ok && armed_q && byte_val != CMD_ACK) begin
        armed_q <= 1'b0;
        dev_o   <= verdict;
      end else if (wait_id_q) begin
        if (tmr_q == TW'(ID_WAIT_CYC - 1)) begin
          wait_id_q <= 1'b0;
          dev_o     <= DEV_KEYBOARD;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
      if (query_i) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx
  import ps2_rx_pkg::*;
#(
  parameter int FILT_LEN    = 8,
  parameter int BIT_TO_CYC  = 10000,
  parameter int ID_WAIT_CYC = 2000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       inhibit_i,
  input  logic       id_query_i,
  output logic       ps2_clk_oe,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       err_pulse,
  output logic [1:0] dev_type
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] lvl;
  logic               frm_ok, frm_err;
  logic [7:0]         frm_byte;
  dev_kind_e          dev_q;
  logic               slot_free;

  assign raw_lines = {ps2_dat_i, ps2_clk_i};

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    ps2_line_filter #(.STABLE_CYC(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (raw_lines[gi]),
      .level_o (lvl[gi])
    );
  end

  ps2_frame_rx #(.BIT_TO_CYC(BIT_TO_CYC)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_lvl  (lvl[0]),
    .dat_lvl  (lvl[1]),
    .hold_i   (inhibit_i),
    .frm_ok   (frm_ok),
    .frm_err  (frm_err),
    .frm_byte (frm_byte)
  );

  ps2_dev_classify #(.ID_WAIT_CYC(ID_WAIT_CYC)) u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_ok  (frm_ok),
    .byte_val (frm_byte),
    .query_i  (id_query_i),
    .dev_o    (dev_q)
  );

  assign dev_type  = dev_q;
  assign slot_free = ~m_valid | m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid    <= 1'b0;
      m_data     <= '0;
      err_pulse  <= 1'b0;
      ps2_clk_oe <= 1'b0;
    end else begin
      ps2_clk_oe <= inhibit_i;
      err_pulse  <= frm_err | (frm_ok & ~slot_free);
      if (frm_ok && slot_free) begin
        m_valid <= 1'b1;
        m_data  <= frm_byte;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ps2_host_rx_chk.sv
module ps2_host_rx_chk
  import ps2_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       inhibit_i,
  input logic       ps2_clk_oe,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       err_pulse,
  input logic [1:0] dev_type,
  input logic       frm_ok,
  input logic       frm_err,
  input logic [7:0] frm_byte
);
  p_oe_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> ps2_clk_oe);
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_i |=> !ps2_clk_oe);
  p_quiet_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (!frm_ok && !frm_err));
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_drop_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok && m_valid && !m_ready) |=> err_pulse);
  p_ok_xor_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_ok && frm_err));
  p_selftest_unknown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok && frm_byte == SELFTEST_OK) |=> (dev_type == DEV_UNKNOWN));
  p_legal_dev_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_type != 2'd3);
endmodule

bind ps2_host_rx ps2_host_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inhibit_i  (inhibit_i),
  .ps2_clk_oe (ps2_clk_oe),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data),
  .err_pulse  (err_pulse),
  .dev_type   (dev_type),
  .frm_ok     (frm_ok),
  .frm_err    (frm_err),
  .frm_byte   (frm_byte)
);

// File: tb/ps2_host_rx_bench.sv
module ps2_host_rx_bench;
  localparam int FILT = 4;
  localparam int BTO  = 100;
  localparam int IDW  = 3000;
  localparam int H    = 20;
  // vector: {byte, mode}; mode 0 good, 1 bad parity, 2 bad stop, 3 bad start
  localparam logic [9:0] VEC [0:7] = '{
    {8'h5A, 2'd0}, {8'h00, 2'd0}, {8'hFF, 2'd0}, {8'h81, 2'd0},
    {8'h3C, 2'd1}, {8'h3C, 2'd2}, {8'h3C, 2'd3}, {8'hE7, 2'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps2_clk_i = 1'b1;
  logic       ps2_dat_i = 1'b1;
  logic       inhibit_i = 1'b0;
  logic       id_query_i = 1'b0;
  logic       m_ready = 1'b0;
  logic       ps2_clk_oe, m_valid, err_pulse;
  logic [7:0] m_data;
  logic [1:0] dev_type;

  int n_chk = 0;
  int n_err = 0;
  int err_seen = 0;
  int err_base = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ps2_host_rx #(.FILT_LEN(FILT), .BIT_TO_CYC(BTO), .ID_WAIT_CYC(IDW)) u_ps2_host_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ps2_clk_i  (ps2_clk_i),
    .ps2_dat_i  (ps2_dat_i),
    .inhibit_i  (inhibit_i),
    .id_query_i (id_query_i),
    .ps2_clk_oe (ps2_clk_oe),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .err_pulse  (err_pulse),
    .dev_type   (dev_type)
  );

  always @(posedge clk) if (rst_n && err_pulse) err_seen <= err_seen + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_err(input string req, input int exp);
    check(req, 32'(err_seen - err_base), 32'(exp));
    err_base = err_seen;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic [1:0] mode,
                            input int nbits, input bit ready_end);
    logic [10:0] w;
    w = {(mode == 2'd2) ? 1'b0 : 1'b1,
         (mode == 2'd1) ? (^b) : ~(^b),
         b,
         (mode == 2'd3) ? 1'b1 : 1'b0};
    for (int i = 0; i < nbits; i++) begin
      ps2_dat_i = w[i];
      repeat (H) @(negedge clk);
      ps2_clk_i = 1'b0;
      if (ready_end && i == 10) begin
        repeat (7) @(negedge clk);
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
        repeat (H - 8) @(negedge clk);
      end else begin
        repeat (H) @(negedge clk);
      end
      ps2_clk_i = 1'b1;
    end
    repeat (H) @(negedge clk);
    ps2_dat_i = 1'b1;
  endtask

  task automatic consume();
    @(negedge clk);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic expect_byte(input string req, input logic [7:0] b);
    check(req, 32'(m_valid), 32'd1);
    check(req, 32'(m_data), 32'(b));
    consume();
  endtask

  task automatic pulse_query();
    @(negedge clk);
    id_query_i = 1'b1;
    @(negedge clk);
    id_query_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R7: reset state
    check("R7 m_valid", 32'(m_valid), 0);
    check("R7 err_pulse", 32'(err_pulse), 0);
    check("R7 dev_type", 32'(dev_type), 0);
    check("R7 clk_oe", 32'(ps2_clk_oe), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    err_base = err_seen;

    // R1 / R2: vector table
    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v][9:2], VEC[v][1:0], 11, 1'b0);
      if (VEC[v][1:0] == 2'd0) begin
        check_err("R1 no error", 0);
        expect_byte("R1 byte", VEC[v][9:2]);
      end else begin
        check_err("R2 error strobe", 1);
        check("R2 no valid", 32'(m_valid), 0);
      end
    end
    check("R7 unknown without self-test", 32'(dev_type), 0);

    // R4: short glitches ignored
    @(negedge clk);
    ps2_clk_i = 1'b0;
    ps2_dat_i = 1'b0;
    repeat (2) @(negedge clk);
    ps2_clk_i = 1'b1;
    ps2_dat_i = 1'b1;
    repeat (50) @(negedge clk);
    check_err("R4 glitch no error", 0);
    check("R4 glitch no valid", 32'(m_valid), 0);
    send_frame(8'h96, 2'd0, 11, 1'b0);
    check_err("R4 aligned frame", 0);
    expect_byte("R4 byte after glitch", 8'h96);

    // R3: stalled word
    send_frame(8'h55, 2'd0, 4, 1'b0);
    repeat (150) @(negedge clk);
    check_err("R3 timeout strobe", 1);
    check("R3 no valid", 32'(m_valid), 0);
    send_frame(8'h2B, 2'd0, 11, 1'b0);
    expect_byte("R3 recovers", 8'h2B);

    // R5: back-pressure
    send_frame(8'h11, 2'd0, 11, 1'b0);
    repeat (30) @(negedge clk);
    check("R5 held valid", 32'(m_valid), 1);
    check("R5 held data", 32'(m_data), 32'h11);
    send_frame(8'h22, 2'd0, 11, 1'b0);
    check_err("R5 drop strobe", 1);
    check("R5 old byte kept", 32'(m_data), 32'h11);
    consume();
    check("R5 emptied", 32'(m_valid), 0);
    send_frame(8'h33, 2'd0, 11, 1'b0);
    send_frame(8'h44, 2'd0, 11, 1'b1);
    check_err("R5 same-cycle no error", 0);
    expect_byte("R5 same-cycle replace", 8'h44);

    // R6: inhibit mid-word
    send_frame(8'h77, 2'd0, 5, 1'b0);
    inhibit_i = 1'b1;
    ps2_clk_i = 1'b0;
    @(negedge clk);
    check("R6 oe follows", 32'(ps2_clk_oe), 1);
    repeat (200) @(negedge clk);
    check_err("R6 silent discard", 0);
    check("R6 no valid", 32'(m_valid), 0);
    ps2_clk_i = 1'b1;
    repeat (20) @(negedge clk);
    inhibit_i = 1'b0;
    @(negedge clk);
    check("R6 oe released", 32'(ps2_clk_oe), 0);
    send_frame(8'h5C, 2'd0, 11, 1'b0);
    check_err("R6 after release", 0);
    expect_byte("R6 byte after release", 8'h5C);

    // R8: mouse
    send_frame(8'hAA, 2'd0, 11, 1'b0);
    consume();
    check("R8 unknown after AA", 32'(dev_type), 0);
    send_frame(8'h00, 2'd0, 11, 1'b0);
    consume();
    check("R8 mouse", 32'(dev_type), 2);

    // R9: keyboard by byte and by timeout
    send_frame(8'hAA, 2'd0, 11, 1'b0);
    consume();
    send_frame(8'h1C, 2'd0, 11, 1'b0);
    consume();
    check("R9 keyboard by byte", 32'(dev_type), 1);
    send_frame(8'hAA, 2'd0, 11, 1'b0);
    consume();
    check("R9 unknown while waiting", 32'(dev_type), 0);
    repeat (1000) @(negedge clk);
    check("R9 still waiting", 32'(dev_type), 0);
    repeat (2500) @(negedge clk);
    check("R9 keyboard by timeout", 32'(dev_type), 1);

    // R10: identity query
    send_frame(8'h00, 2'd0, 11, 1'b0);
    consume();
    check("R10 unsolicited zero ignored", 32'(dev_type), 1);
    pulse_query();
    send_frame(8'hFA, 2'd0, 11, 1'b0);
    consume();
    check("R10 ack skipped", 32'(dev_type), 1);
    send_frame(8'h00, 2'd0, 11, 1'b0);
    consume();
    check("R10 mouse reply", 32'(dev_type), 2);
    pulse_query();
    send_frame(8'hFA, 2'd0, 11, 1'b0);
    consume();
    send_frame(8'hAB, 2'd0, 11, 1'b0);
    consume();
    check("R10 keyboard reply", 32'(dev_type), 1);
    check_err("R10 no stray errors", 0);

    done = 1'b1;
    finish_run();
  end
endmodule